// File: doc/BRIEF.md
# Serial Flash Identification and Status Responder

This block is the byte-level slave side of a serial NOR flash interface. It is limited to the identification and status commands. A byte deserializer in front of it reports whether the device is selected and strobes each byte it receives from the host. In return, the block supplies the byte that the serializer will shift out in the next byte slot. Array storage, erase and program timing are not part of this block.

The block holds an 8-bit status word. Only the write-enable latch in that word can change state. Writing is limited to the two latch commands. Status can be read on any number of consecutive slots within one selection. The two-byte ID command lets the host choose whether the manufacturer code or the device code comes first. The manufacturer code and device code are parameters. The device code is meant to be 0x14, 0x15 or 0x16, and its default is 0x14.

Top module: `spi_idr_top`

## Requirements
- R1: After reset the reply byte is 0xFF and the write-enable latch is clear.
- R2: The status byte is laid out as: bit 0 write in progress, bit 1 write-enable latch, bits 5:2 block protect, bit 6 continuous-program mode, bit 7 status-write disable. In this block every bit except bit 1 reads 0.
- R3: The reply is 0xFF during the opcode slot of every selection, and on every slot of any opcode other than 0x05, 0x9F and 0x90.
- R4: After opcode 0x05, each later slot in the same selection carries the current status byte, however many slots the host clocks.
- R5: After opcode 0x9F, the next three slots carry the manufacturer code, then 0x20, then the device code. Slots after those carry 0xFF.
- R6: After opcode 0x90, slots 1 and 2 are dummies and slot 3 is a selector, and all three reply 0xFF. Selector 0x00 makes slots 4 and 5 reply manufacturer then device. Any other selector value reverses that order. Later slots reply 0xFF.
- R7: A selection that holds only opcode 0x06 sets the latch when the select ends. A selection that holds only 0x04 clears it.
- R8: The latch never changes while the device is selected. A 0x06 or 0x04 selection that contains more than one byte leaves the latch unchanged.
- R9: The slot count restarts at every select start. A byte strobe in the same cycle as the select start is taken as the opcode.
- R10: Byte strobes while the device is deselected are ignored, including a strobe in the cycle that the select ends.
- R11: The reply byte changes only in the cycle after an accepted byte, or after a select start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | High while the host selects the device |
| rx_valid | input | 1 | One-cycle strobe: a host byte is present |
| rx_byte | input | 8 | Host byte received in this slot |
| tx_byte | output | 8 | Byte to send in the next slot |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a select start and the first byte strobe. The bench raises both on the same edge with a status-read opcode and expects the status byte one cycle later, not 0xFF. The second pair is a select end and a stray byte strobe. The bench ends a lone write-enable selection with a strobe in the deselect cycle and then reads status. It expects bit 1 set, which shows the stray byte was neither counted nor allowed to block the latch update.

// File: rtl/spi_idr_pkg.sv
package spi_idr_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_RDID   = 8'h9F;
    localparam logic [7:0] OP_REMS   = 8'h90;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam logic [7:0] MEM_TYPE  = 8'h20;

    // Status word; field order sets the bit positions (bit 7 first)
    typedef struct packed {
        logic       wr_lock;   // bit 7 status-write disable
        logic       cont_prog; // bit 6 continuous-program mode
        logic [3:0] prot;      // bits 5:2 block protect
        logic       wen;       // bit 1 write-enable latch
        logic       busy;      // bit 0 write in progress
    } stat_t;

    function automatic logic [7:0] stat_to_byte(stat_t s);
        return s;
    endfunction

    function automatic logic is_latch_op(logic [7:0] op);
        return (op == OP_WREN) || (op == OP_WRDI);
    endfunction

endpackage

// File: rtl/spi_idr_slot_track.sv
module spi_idr_slot_track
    import spi_idr_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             sel_start,
    output logic             sel_end,
    output logic             byte_acc,
    output logic [CNT_W-1:0] cur_idx,
    output logic [CNT_W-1:0] cnt_q,
    output logic [7:0]       opcode_now,
    output logic [7:0]       opcode_q
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic cs_q;

    assign sel_start  = cs_active & ~cs_q;
    assign sel_end    = ~cs_active & cs_q;
    assign byte_acc   = rx_valid & cs_active;
    assign cur_idx    = sel_start ? '0 : cnt_q;
    assign opcode_now = (cur_idx == '0) ? rx_byte : opcode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= 1'b0;
            cnt_q    <= '0;
            opcode_q <= IDLE_BYTE;
        end else begin
            cs_q <= cs_active;
            if (byte_acc) begin
                cnt_q <= (cur_idx == CMAX) ? cur_idx : cur_idx + 1'b1;
                if (cur_idx == '0)
                    opcode_q <= rx_byte;
            end else if (sel_start) begin
                cnt_q <= '0;
            end
        end
    end

    AST_CNT_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        (sel_start && !rx_valid) |=> (cnt_q == '0)); // R9
    AST_FIRST_BYTE_ONE: assert property (@(posedge clk) disable iff (rst)
        (sel_start && rx_valid) |=> (cnt_q == CNT_W'(1))); // R9
    AST_DESEL_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!cs_active) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/spi_idr_status.sv
module spi_idr_status
    import spi_idr_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_active,
    input  logic             sel_end,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [7:0]       opcode_q,
    output stat_t            stat
);
    logic wen_q;
    logic commit;

    // Latch ops take effect only for a one-byte selection, on its end
    assign commit = sel_end && (cnt_q == CNT_W'(1)) && is_latch_op(opcode_q);

    always_ff @(posedge clk) begin
        if (rst)
            wen_q <= 1'b0;
        else if (commit)
            wen_q <= (opcode_q == OP_WREN);
    end

    always_comb begin
        stat           = '0;
        stat.wen       = wen_q;
        stat.busy      = 1'b0;
        stat.prot      = 4'h0;
        stat.cont_prog = 1'b0;
        stat.wr_lock   = 1'b0;
    end

    AST_WEN_HOLD_SELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_active |=> $stable(wen_q)); // R8
    AST_WEN_SET: assert property (@(posedge clk) disable iff (rst)
        (sel_end && cnt_q == CNT_W'(1) && opcode_q == OP_WREN) |=> wen_q); // R7
    AST_WEN_CLR: assert property (@(posedge clk) disable iff (rst)
        (sel_end && cnt_q == CNT_W'(1) && opcode_q == OP_WRDI) |=> !wen_q); // R7
    AST_WEN_LONG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sel_end && cnt_q != CNT_W'(1)) |=> $stable(wen_q)); // R8

endmodule

// File: rtl/spi_idr_reply.sv
module spi_idr_reply
    import spi_idr_pkg::*;
#(
    parameter int         CNT_W  = 3,
    parameter logic [7:0] MFR_ID = 8'hC2,
    parameter logic [7:0] DEV_ID = 8'h14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_start,
    input  logic             byte_acc,
    input  logic [CNT_W-1:0] cur_idx,
    input  logic [7:0]       opcode_now,
    input  logic [7:0]       rx_byte,
    input  stat_t            stat,
    output logic [7:0]       tx_byte
);
    localparam logic [CNT_W-1:0] SLOT_SEL  = CNT_W'(3);
    localparam logic [CNT_W-1:0] SLOT_ID2  = CNT_W'(4);

    logic [7:0] tx_q;
    logic [7:0] nxt;
    logic       mfr_first_q;

    // Reply for the slot after the byte just accepted at index cur_idx
    always_comb begin
        nxt = IDLE_BYTE;
        case (opcode_now)
            OP_RDSR: nxt = stat_to_byte(stat);
            OP_RDID: begin
                if (cur_idx == CNT_W'(0))      nxt = MFR_ID;
                else if (cur_idx == CNT_W'(1)) nxt = MEM_TYPE;
                else if (cur_idx == CNT_W'(2)) nxt = DEV_ID;
            end
            OP_REMS: begin
                if (cur_idx == SLOT_SEL)
                    nxt = (rx_byte == 8'h00) ? MFR_ID : DEV_ID;
                else if (cur_idx == SLOT_ID2)
                    nxt = mfr_first_q ? DEV_ID : MFR_ID;
            end
            default: nxt = IDLE_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q        <= IDLE_BYTE;
            mfr_first_q <= 1'b1;
        end else begin
            if (byte_acc) begin
                tx_q <= nxt;
                if (opcode_now == OP_REMS && cur_idx == SLOT_SEL)
                    mfr_first_q <= (rx_byte == 8'h00);
            end else if (sel_start) begin
                tx_q <= IDLE_BYTE;
            end
        end
    end

    assign tx_byte = tx_q;

    AST_IDLE_AT_START: assert property (@(posedge clk) disable iff (rst)
        (sel_start && !byte_acc) |=> (tx_q == IDLE_BYTE)); // R3
    AST_STATUS_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (byte_acc && opcode_now == OP_RDSR) |=> (tx_q == $past(stat_to_byte(stat)))); // R4
    AST_MEMTYPE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (byte_acc && opcode_now == OP_RDID && cur_idx == CNT_W'(1)) |=> (tx_q == MEM_TYPE)); // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!byte_acc && !sel_start) |=> $stable(tx_q)); // R11

endmodule

// File: rtl/spi_idr_top.sv
module spi_idr_top
    import spi_idr_pkg::*;
#(
    parameter int         CNT_W  = 3,
    parameter logic [7:0] MFR_ID = 8'hC2,
    parameter logic [7:0] DEV_ID = 8'h14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_active,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tx_byte
);
    logic             sel_start;
    logic             sel_end;
    logic             byte_acc;
    logic [CNT_W-1:0] cur_idx;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       opcode_now;
    logic [7:0]       opcode_q;
    stat_t            stat;

    spi_idr_slot_track #(.CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .cs_active  (cs_active),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .sel_start  (sel_start),
        .sel_end    (sel_end),
        .byte_acc   (byte_acc),
        .cur_idx    (cur_idx),
        .cnt_q      (cnt_q),
        .opcode_now (opcode_now),
        .opcode_q   (opcode_q)
    );

    spi_idr_status #(.CNT_W(CNT_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .cs_active (cs_active),
        .sel_end   (sel_end),
        .cnt_q     (cnt_q),
        .opcode_q  (opcode_q),
        .stat      (stat)
    );

    spi_idr_reply #(.CNT_W(CNT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_reply (
        .clk        (clk),
        .rst        (rst),
        .sel_start  (sel_start),
        .byte_acc   (byte_acc),
        .cur_idx    (cur_idx),
        .opcode_now (opcode_now),
        .rx_byte    (rx_byte),
        .stat       (stat),
        .tx_byte    (tx_byte)
    );

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat.busy == 1'b0 && stat.prot == 4'h0 && !stat.cont_prog && !stat.wr_lock)); // R2

endmodule

// File: tb/spi_idr_top_tb.sv
module spi_idr_top_tb;

    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] DEV = 8'h14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_active = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;

    int    total = 0;
    int    bad = 0;
    bit    run = 0;
    bit    done = 0;
    string cur_req = "R11";

    // behavioural reference state
    logic [7:0] mq[$];
    logic [7:0] exp_tx = 8'hFF;
    bit         m_wen = 0;
    bit         m_prev_cs = 0;

    always #10 clk = ~clk;

    spi_idr_top u_dut (
        .clk(clk), .rst(rst), .cs_active(cs_active),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    function automatic logic [7:0] model_reply();
        int n = mq.size();
        logic [7:0] op = mq[0];
        if (op == 8'h05) return {6'b0, m_wen, 1'b0};
        if (op == 8'h9F) begin
            if (n == 1) return MFR;
            if (n == 2) return 8'h20;
            if (n == 3) return DEV;
            return 8'hFF;
        end
        if (op == 8'h90) begin
            if (n == 4) return (mq[3] == 8'h00) ? MFR : DEV;
            if (n == 5) return (mq[3] == 8'h00) ? DEV : MFR;
            return 8'hFF;
        end
        return 8'hFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_tx = 8'hFF; m_wen = 0; m_prev_cs = 0; mq.delete();
        end else begin
            if (cs_active && !m_prev_cs) begin
                mq.delete();
                if (!rx_valid) exp_tx = 8'hFF;
            end
            if (cs_active && rx_valid) begin
                mq.push_back(rx_byte);
                exp_tx = model_reply();
            end
            if (!cs_active && m_prev_cs && mq.size() == 1) begin
                if (mq[0] == 8'h06) m_wen = 1;
                if (mq[0] == 8'h04) m_wen = 0;
            end
            m_prev_cs = cs_active;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (run && !rst) chk(cur_req, tx_byte, exp_tx);
    end

    task automatic sel();
        @(negedge clk) cs_active = 1'b1;
        @(negedge clk);
    endtask

    task automatic desel();
        @(negedge clk) cs_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic read_status(string req, logic [7:0] exp);
        sel();
        send(8'h05);
        chk(req, tx_byte, exp);
        desel();
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1;
        @(negedge clk);
        cur_req = "R1"; chk("R1", tx_byte, 8'hFF);
        read_status("R1", 8'h00);

        // R3: opcode slot idles, R4: repeated status, R2 layout
        cur_req = "R3"; sel(); chk("R3", tx_byte, 8'hFF);
        cur_req = "R4"; send(8'h05); chk("R2", tx_byte, 8'h00);
        for (int i = 0; i < 3; i++) begin send(8'h00); chk("R4", tx_byte, 8'h00); end
        desel();

        // R7: lone write enable sets latch at select end
        cur_req = "R7"; sel(); send(8'h06); chk("R3", tx_byte, 8'hFF); desel();
        sel(); send(8'h05); chk("R7", tx_byte, 8'h02);
        for (int i = 0; i < 4; i++) begin send(8'hA5); chk("R4", tx_byte, 8'h02); end
        desel();

        // R8: latch op with extra byte ignored
        cur_req = "R8"; sel(); send(8'h04); send(8'h00); desel();
        read_status("R8", 8'h02);
        cur_req = "R7"; sel(); send(8'h04); desel();
        read_status("R7", 8'h00);

        // R5: JEDEC ID sequence
        cur_req = "R5"; sel(); send(8'h9F); chk("R5", tx_byte, MFR);
        send(8'h00); chk("R5", tx_byte, 8'h20);
        send(8'h00); chk("R5", tx_byte, DEV);
        send(8'h00); chk("R5", tx_byte, 8'hFF);
        desel();

        // R6: manufacturer/device ID, both orders
        cur_req = "R6";
        for (int s = 0; s < 2; s++) begin
            sel(); send(8'h90); chk("R6", tx_byte, 8'hFF);
            send(8'h00); chk("R6", tx_byte, 8'hFF);
            send(8'h00); chk("R6", tx_byte, 8'hFF);
            send(s == 0 ? 8'h00 : 8'h01);
            chk("R6", tx_byte, s == 0 ? MFR : DEV);
            send(8'h00); chk("R6", tx_byte, s == 0 ? DEV : MFR);
            send(8'h00); chk("R6", tx_byte, 8'hFF);
            desel();
        end

        // R3: unsupported opcode
        cur_req = "R3"; sel(); send(8'hAB); chk("R3", tx_byte, 8'hFF);
        send(8'h05); chk("R3", tx_byte, 8'hFF); desel();

        // R9: strobe in the select-start cycle is the opcode
        cur_req = "R9";
        @(negedge clk) begin cs_active = 1'b1; rx_valid = 1'b1; rx_byte = 8'h06; end
        @(negedge clk) rx_valid = 1'b0;
        chk("R9", tx_byte, 8'hFF);
        // R10: strobe in the deselect cycle is dropped; commit still happens
        @(negedge clk) begin cs_active = 1'b0; rx_valid = 1'b1; rx_byte = 8'h00; end
        @(negedge clk) rx_valid = 1'b0;
        cur_req = "R10"; read_status("R10", 8'h02);
        @(negedge clk) begin cs_active = 1'b1; rx_valid = 1'b1; rx_byte = 8'h05; end
        @(negedge clk) rx_valid = 1'b0;
        chk("R9", tx_byte, 8'h02);
        desel();

        // R10: strobes while deselected change nothing
        send(8'h04);
        chk("R10", tx_byte, 8'h02);
        read_status("R10", 8'h02);

        // R11: reply holds when no byte arrives
        cur_req = "R11"; sel(); send(8'h9F);
        repeat (3) @(negedge clk);
        chk("R11", tx_byte, MFR);
        desel();

        done = 1;
        finish_up();
    end

endmodule